// File: doc/BRIEF.md
# Printer Acknowledge Interrupt Generator

This block turns a printer's active-low acknowledge line into the printer-port interrupt. The acknowledge line idles high. A strap input picks one of two behaviours.

- **Follow mode:** the interrupt level tracks acknowledge after a short synchronizer delay.
- **Latched mode:** a falling acknowledge edge sets a pending flag. The flag holds until the host completes a read of the printer port. Completion is the rising edge of the read strobe while the printer chip select is active.

A build-time parameter sets the level that drives the line in latched mode, active high or active low. When the control register's interrupt-enable bit is clear, the pad driver is switched off. The block has no tri-state pin of its own: it gives a level and an output enable to the pad cell. The enable bit being clear also discards any pending flag.

All external inputs pass through a synchronizer. Acknowledge events and end-of-read events are found as edges of the synchronized signals. When both events land in the same cycle, the acknowledge event wins, so no interrupt is lost.

Top module: `prn_ack_irq`

## Requirements
- R1: While reset is held and right after reset, `irqOe` is 0 and no latched interrupt is pending.
- R2: `irqOe` equals the value `irqEnable` had one clock earlier.
- R3: With `latchMode`=0, `irqLevel` equals the value `ackN` had SYNC_STAGES (default 2) clocks earlier.
- R4: With `latchMode`=1, a high-to-low transition of `ackN` makes `irqLevel` show the asserted level SYNC_STAGES+1 clocks later, and not before.
- R5: A pending latched interrupt stays asserted after `ackN` returns high.
- R6: A low-to-high transition of `rdN` while `csN`=0 clears the pending interrupt. `irqLevel` becomes inactive SYNC_STAGES+1 clocks after that transition.
- R7: A rising `rdN` while `csN`=1 does not clear the pending interrupt.
- R8: When an acknowledge falling edge and an end-of-read edge reach the synchronized domain in the same cycle, the interrupt stays pending.
- R9: Driving `irqEnable` low clears any pending interrupt. After re-enabling, `irqLevel` shows the inactive level.
- R10: In latched mode the asserted level is 1 when ACTIVE_LOW_LATCHED=0 and 0 when ACTIVE_LOW_LATCHED=1. The inactive level is the opposite.
- R11: Only a falling edge of `ackN` sets the interrupt. Holding `ackN` low after a clear does not set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackN | input | 1 | Printer acknowledge, active low, asynchronous |
| latchMode | input | 1 | Mode strap: 0 follow, 1 latched |
| irqEnable | input | 1 | Interrupt-enable bit from the port control register |
| rdN | input | 1 | Host read strobe, active low, asynchronous |
| csN | input | 1 | Printer port chip select, active low, asynchronous |
| irqLevel | output | 1 | Level for the interrupt pad |
| irqOe | output | 1 | Output enable for the interrupt pad; 0 means high impedance |

## Verification
The assertions assume the following about the inputs:
- `irqEnable` and `latchMode` are synchronous to `clk`.
- `csN` is held active from before the read strobe falls until after it rises, so the qualifier seen with the synchronized rising edge is meaningful.
- `ackN` is driven as an asynchronous line with no glitch narrower than a clock.

The stimulus changes every input only on the falling clock edge. It keeps chip select low for several cycles on both sides of each read edge, and holds each acknowledge level for at least SYNC_STAGES cycles. The one exception is the set-versus-clear case, where the acknowledge fall and the read rise are driven on the same edge on purpose.

// File: rtl/prn_ack_irq_pkg.sv
package prn_ack_irq_pkg;

  // Strobes from the control side into the datapath.
  typedef struct packed {
    logic setEvt;    // synchronized acknowledge falling edge
    logic clrEvt;    // end of a qualified host read
    logic ackLevel;  // synchronized acknowledge level
  } irqStrobes_t;

endpackage

// File: rtl/prn_ack_irq_sync.sv
module prn_ack_irq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/prn_ack_irq_ctrl.sv
module prn_ack_irq_ctrl
  import prn_ack_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackN,
  input  logic        rdN,
  input  logic        csN,
  output irqStrobes_t strobes
);

  logic ackSync, rdSync, csSync;
  logic ackPrev, rdPrev;

  prn_ack_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uAckSync (
    .clk(clk), .rstN(rstN), .din(ackN), .dout(ackSync));
  prn_ack_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uRdSync (
    .clk(clk), .rstN(rstN), .din(rdN), .dout(rdSync));
  prn_ack_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev <= 1'b1;
      rdPrev  <= 1'b1;
    end else begin
      ackPrev <= ackSync;
      rdPrev  <= rdSync;
    end
  end

  always_comb begin
    strobes.setEvt   = ackPrev & ~ackSync;
    strobes.clrEvt   = ~rdPrev & rdSync & ~csSync;
    strobes.ackLevel = ackSync;
  end

  // R11: the acknowledge line must rise again before the next event.
  a_r11_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setEvt |=> !strobes.setEvt);

  // R6: a read end is a single-cycle strobe.
  a_r6_clr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrEvt |=> !strobes.clrEvt);

endmodule

// File: rtl/prn_ack_irq_dp.sv
module prn_ack_irq_dp
  import prn_ack_irq_pkg::*;
#(
  parameter bit ACTIVE_LOW_LATCHED = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  irqStrobes_t strobes,
  input  logic        latchMode,
  input  logic        irqEnable,
  output logic        irqLevel,
  output logic        irqOe
);

  localparam logic ASSERTED_LVL = ACTIVE_LOW_LATCHED ? 1'b0 : 1'b1;
  localparam logic IDLE_LVL     = ~ASSERTED_LVL;

  logic enQ;
  logic latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= 1'b0;
    else       enQ <= irqEnable;
  end

  // Priority: disable, then new event, then read end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         latchQ <= 1'b0;
    else if (!irqEnable || !latchMode) latchQ <= 1'b0;
    else if (strobes.setEvt)           latchQ <= 1'b1;
    else if (strobes.clrEvt)           latchQ <= 1'b0;
  end

  always_comb begin
    irqOe = enQ;
    if (latchMode) irqLevel = latchQ ? ASSERTED_LVL : IDLE_LVL;
    else           irqLevel = strobes.ackLevel;
  end

  // R2: output enable follows the enable bit one clock later.
  a_r2_oe_on: assert property (@(posedge clk) disable iff (!rstN)
    irqEnable |=> irqOe);
  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> !irqOe);

  // R8: a new acknowledge edge always leaves the interrupt pending.
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && latchMode && strobes.setEvt) |=> latchQ);

  // R6: a lone read end clears.
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && latchMode && strobes.clrEvt && !strobes.setEvt) |=> !latchQ);

  // R5: with no event the pending state holds.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && latchMode && !strobes.setEvt && !strobes.clrEvt) |=> $stable(latchQ));

  // R9: disabling discards the pending interrupt.
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> !latchQ);

endmodule

// File: rtl/prn_ack_irq.sv
module prn_ack_irq
  import prn_ack_irq_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter bit ACTIVE_LOW_LATCHED = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic ackN,
  input  logic latchMode,
  input  logic irqEnable,
  input  logic rdN,
  input  logic csN,
  output logic irqLevel,
  output logic irqOe
);

  irqStrobes_t strobes;

  prn_ack_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .ackN(ackN), .rdN(rdN), .csN(csN),
    .strobes(strobes));

  prn_ack_irq_dp #(.ACTIVE_LOW_LATCHED(ACTIVE_LOW_LATCHED)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .latchMode(latchMode),
    .irqEnable(irqEnable), .irqLevel(irqLevel), .irqOe(irqOe));

  // R1: reset leaves the pad undriven.
  a_r1_reset_oe: assert property (@(posedge clk) !rstN |=> !irqOe);

endmodule

// File: tb/prn_ack_irq_test.sv
`timescale 1ns/1ps
module prn_ack_irq_test;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN, ackN, latchMode, irqEnable, rdN, csN;
  logic lvlHi, oeHi, lvlLo, oeLo;
  int   total = 0;
  int   fails = 0;

  always #2.5 clk = ~clk;

  prn_ack_irq #(.SYNC_STAGES(SYNC), .ACTIVE_LOW_LATCHED(1'b0)) uut (
    .clk(clk), .rstN(rstN), .ackN(ackN), .latchMode(latchMode),
    .irqEnable(irqEnable), .rdN(rdN), .csN(csN),
    .irqLevel(lvlHi), .irqOe(oeHi));

  prn_ack_irq #(.SYNC_STAGES(SYNC), .ACTIVE_LOW_LATCHED(1'b1)) uutLow (
    .clk(clk), .rstN(rstN), .ackN(ackN), .latchMode(latchMode),
    .irqEnable(irqEnable), .rdN(rdN), .csN(csN),
    .irqLevel(lvlLo), .irqOe(oeLo));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Latched-mode level check on both variants (R10).
  task automatic chkPend(string tag, bit pending);
    chk({tag, " R10 high variant"}, lvlHi, pending ? 1'b1 : 1'b0);
    chk({tag, " R10 low variant"},  lvlLo, pending ? 1'b0 : 1'b1);
  endtask

  // Qualified read: strobe low, then rising with chip select held low.
  task automatic hostRead(int lowCycles);
    csN = 1'b0; rdN = 1'b0;
    tick(lowCycles);
    rdN = 1'b1;
  endtask

  initial begin
    #500000;
    fails++; total++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; ackN = 1'b1; latchMode = 1'b0; irqEnable = 1'b0;
    rdN = 1'b1; csN = 1'b1;
    tick(3);
    chk("R1 oe during reset", oeHi, 1'b0);
    chk("R1 oe during reset low variant", oeLo, 1'b0);
    rstN = 1'b1;
    tick(1);
    chk("R1 oe after reset", oeHi, 1'b0);

    irqEnable = 1'b1;
    tick(1);
    chk("R2 oe on", oeHi, 1'b1);
    chk("R2 oe on low variant", oeLo, 1'b1);

    // R3: follow mode, sweep all 4-bit acknowledge patterns.
    for (int v = 0; v < 16; v++) begin
      for (int b = 0; b < 4; b++) begin
        ackN = v[b];
        tick(SYNC);
        chk("R3 follow high variant", lvlHi, v[b]);
        chk("R3 follow low variant",  lvlLo, v[b]);
      end
    end

    ackN = 1'b1;
    latchMode = 1'b1;
    tick(4);
    chkPend("R1 no pending", 1'b0);

    // R4..R7 swept over read pulse widths.
    for (int w = 1; w <= 4; w++) begin
      ackN = 1'b0;
      tick(SYNC);
      chkPend("R4 not yet", 1'b0);
      tick(1);
      chkPend("R4 set", 1'b1);
      ackN = 1'b1;
      tick(4);
      chkPend("R5 held after ack rise", 1'b1);
      csN = 1'b1; rdN = 1'b0;
      tick(w + 1);
      rdN = 1'b1;
      tick(4);
      chkPend("R7 unselected read", 1'b1);
      hostRead(w + 1);
      tick(SYNC);
      chkPend("R6 before clear", 1'b1);
      tick(1);
      chkPend("R6 cleared", 1'b0);
      tick(2);
      csN = 1'b1;
      tick(2);
    end

    // R11: acknowledge held low does not set again.
    ackN = 1'b0;
    tick(4);
    chkPend("R11 first edge", 1'b1);
    hostRead(3);
    tick(4);
    csN = 1'b1;
    tick(4);
    chkPend("R11 level ignored", 1'b0);
    ackN = 1'b1;
    tick(4);

    // R8: set and clear in the same cycle.
    ackN = 1'b0;
    tick(4);
    ackN = 1'b1;
    csN = 1'b0; rdN = 1'b0;
    tick(4);
    ackN = 1'b0; rdN = 1'b1;
    tick(4);
    chkPend("R8 set wins", 1'b1);
    ackN = 1'b1;
    tick(2);
    csN = 1'b1;
    tick(2);
    hostRead(2);
    tick(4);
    csN = 1'b1;
    chkPend("R8 later read clears", 1'b0);

    // R9: disable discards pending.
    ackN = 1'b0;
    tick(4);
    chkPend("R9 pending", 1'b1);
    ackN = 1'b1;
    irqEnable = 1'b0;
    tick(1);
    chk("R2 oe off", oeHi, 1'b0);
    chk("R2 oe off low variant", oeLo, 1'b0);
    tick(1);
    irqEnable = 1'b1;
    tick(1);
    chk("R9 oe back", oeHi, 1'b1);
    chkPend("R9 cleared", 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule